// File: doc/BRIEF.md
# SPI Register Control Port

This block is a serial slave that lets a host controller read and write a small bank of 8-bit control registers. The host lowers an active-low select line, toggles a bit clock and drives a data-in line. It can also read back a data-out line that the block drives only while it is returning register contents. Every frame opens with an address byte. Its upper seven bits are a fixed device identifier and its lowest bit chooses the direction. A frame whose identifier does not match has no effect on the block.

In a write frame, the byte after the address byte loads the register pointer. Each later byte is stored into the register the pointer selects, and the pointer then advances. In a read frame, the block shifts out the register at the current pointer, starting right after the address byte, and moves on to the next register for each further byte. The pointer keeps its value between frames. A host therefore sets the pointer with a short write frame and then reads from that point.

All three host lines are asynchronous to the block. They pass through a synchroniser and an edge detector running on the system clock. The bit clock must therefore stay high and low for several system clock cycles. The register contents are also presented in parallel, so that the logic around the block can use them.

Top module: `spi_regport`

## Requirements
- R1: After a synchronous reset, every register reads 0x00 on `regs_o` and `miso_oe_o` is low.
- R2: A frame runs while `cs_n_i` is low. Bits are captured on rising edges of `sck_i`, most significant bit first. The first byte holds the identifier 7'b1001100 in bits 7..1 and the direction in bit 0 (0 = write, 1 = read).
- R3: If the identifier does not match, the rest of the frame is ignored: no register changes and `miso_oe_o` stays low.
- R4: In a write frame, byte two loads the pointer and byte three is stored into register[pointer]. The stored value appears on `regs_o` within 4 clock cycles of the rising `sck_i` edge that carries its last bit.
- R5: The pointer advances by one after each completed data byte, so further bytes in one write frame fill consecutive registers. The pointer is 8 bits wide and wraps from 255 to 0.
- R6: In a read frame, register[pointer] is shifted out on `miso_o` after the address byte, most significant bit first. Each bit changes after a falling edge of `sck_i`. Further bytes in the frame return consecutive registers.
- R7: `miso_oe_o` is high only in the data phase of a matching read frame. It rises from the first falling `sck_i` edge after the address byte and falls within 4 cycles of `cs_n_i` rising. While it is low, `miso_o` is high-impedance.
- R8: If `cs_n_i` rises partway through a byte, that byte is discarded. A partial data byte writes nothing, and a partial pointer byte leaves the pointer unchanged.
- R9: A pointer at or above the register count drops writes, and reads at that pointer return 0x00.
- R10: The pointer keeps its value from one frame to the next, so a read frame starts at the pointer left by the previous frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Asynchronous active-low frame select |
| sck_i | input | 1 | Asynchronous serial bit clock |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host, high-impedance when not driven |
| miso_oe_o | output | 1 | High while `miso_o` is driven |
| regs_o | output | NREG*8 | All registers in parallel, register k at bits 8k+7..8k |

## Verification
Each host line passes two synchroniser stages and one edge-detect stage before the sequencer acts on it. A stored byte therefore reaches `regs_o` about four cycles after its last rising bit-clock edge. A read bit settles on `miso_o` about three cycles after a falling edge, and the output enable drops about three cycles after select rises. The bench holds each bit-clock level for eight system cycles and samples every result at the end of that half period, on the falling edge of the system clock. It samples a read bit just before it raises the bit clock and checks `regs_o` one half period after the last bit of a byte. Each result is sampled only after its latency has passed, and before the next stimulus could change it.

// File: rtl/spi_regport_pkg.sv
// Shared types and constants for the serial register control port.
// Assumes: one 8-bit word per register and an 8-bit pointer.
package spi_regport_pkg;

    localparam int BYTE_W = 8;
    localparam logic [6:0] DEFAULT_DEV_ID = 7'b1001100;

    // Phase of the frame sequencer.
    typedef enum logic [2:0] {
        PH_IDLE,    // select high, no frame
        PH_ADDR,    // collecting identifier and direction
        PH_PTR,     // collecting pointer byte of a write frame
        PH_WDATA,   // collecting data bytes of a write frame
        PH_RDATA,   // returning register bytes
        PH_IGNORE   // identifier mismatch, wait for select to rise
    } phase_t;

endpackage

// File: rtl/spi_regport_sync.sv
// Brings a group of asynchronous single-bit lines into the clock domain
// and detects their edges.
// Assumes: each line holds every level for more than STAGES+1 clocks.
// Outputs: synchronised level, plus one-cycle rise and fall strobes.
module spi_regport_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] prev_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain_q;

        // Metastability chain for one line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[g]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[g]};
            end
        end

        assign level_o[g] = chain_q[STAGES-1];
    end

    // Level of the previous cycle, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= level_o;
        end
    end

    assign rise_o = level_o & ~prev_q;
    assign fall_o = ~level_o & prev_q;

endmodule

// File: rtl/spi_regport_frame.sv
// Frame sequencer: it decodes the address byte, holds the pointer,
// issues write strobes and shifts read data out.
// Assumes: the inputs are already synchronised, and each sck strobe is a
// single cycle. The pointer persists across frames.
module spi_regport_frame
    import spi_regport_pkg::*;
#(
    parameter logic [6:0] DEV_ID = DEFAULT_DEV_ID
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] ptr_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              miso_bit_o,
    output logic              miso_oe_o,
    output phase_t            phase_o
);

    localparam int CNT_W = $clog2(BYTE_W);

    phase_t            phase_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-2:0] rx_sh_q;
    logic [BYTE_W-2:0] tx_sh_q;
    logic [BYTE_W-1:0] ptr_q;
    logic              wr_en_q;
    logic [BYTE_W-1:0] wr_addr_q;
    logic [BYTE_W-1:0] wr_data_q;
    logic              miso_q;
    logic              oe_q;

    logic [BYTE_W-1:0] byte_in;
    logic              byte_done;
    logic              shifting;

    // Byte assembled from the held bits and the bit arriving now.
    always_comb begin
        byte_in   = {rx_sh_q, mosi};
        byte_done = sck_rise && (bit_cnt_q == CNT_W'(BYTE_W - 1));
        shifting  = (phase_q != PH_IDLE) && (phase_q != PH_IGNORE);
    end

    // Phase, bit counter and receive shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            bit_cnt_q <= '0;
            rx_sh_q   <= '0;
        end else if (cs_n) begin
            phase_q   <= PH_IDLE;
            bit_cnt_q <= '0;
        end else if (phase_q == PH_IDLE) begin
            phase_q   <= PH_ADDR;
            bit_cnt_q <= '0;
        end else if (sck_rise && shifting) begin
            rx_sh_q   <= byte_in[BYTE_W-2:0];
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (byte_done) begin
                case (phase_q)
                    PH_ADDR: begin
                        if (byte_in[BYTE_W-1:1] != DEV_ID) begin
                            phase_q <= PH_IGNORE;
                        end else if (byte_in[0]) begin
                            phase_q <= PH_RDATA;
                        end else begin
                            phase_q <= PH_PTR;
                        end
                    end
                    PH_PTR:  phase_q <= PH_WDATA;
                    default: phase_q <= phase_q;
                endcase
            end
        end
    end

    // Pointer load and advance, and the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (!cs_n && byte_done) begin
                case (phase_q)
                    PH_PTR: ptr_q <= byte_in;
                    PH_WDATA: begin
                        wr_en_q   <= 1'b1;
                        wr_addr_q <= ptr_q;
                        wr_data_q <= byte_in;
                        ptr_q     <= ptr_q + 1'b1;
                    end
                    PH_RDATA: ptr_q <= ptr_q + 1'b1;
                    default: ptr_q <= ptr_q;
                endcase
            end
        end
    end

    // Read shifter, which moves on falling sck edges in the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh_q <= '0;
            miso_q  <= 1'b0;
            oe_q    <= 1'b0;
        end else if (cs_n) begin
            oe_q <= 1'b0;
        end else if (sck_fall && phase_q == PH_RDATA) begin
            oe_q <= 1'b1;
            if (bit_cnt_q == '0) begin
                miso_q  <= rd_data[BYTE_W-1];
                tx_sh_q <= rd_data[BYTE_W-2:0];
            end else begin
                miso_q  <= tx_sh_q[BYTE_W-2];
                tx_sh_q <= {tx_sh_q[BYTE_W-3:0], 1'b0};
            end
        end
    end

    assign ptr_o      = ptr_q;
    assign wr_en_o    = wr_en_q;
    assign wr_addr_o  = wr_addr_q;
    assign wr_data_o  = wr_data_q;
    assign miso_bit_o = miso_q;
    assign miso_oe_o  = oe_q;
    assign phase_o    = phase_q;

endmodule

// File: rtl/spi_regport_regfile.sv
// Bank of NREG 8-bit registers with one write port and one read port.
// Assumes: NREG <= 256. Addresses at or above NREG write nothing and
// read as zero.
module spi_regport_regfile
    import spi_regport_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [BYTE_W-1:0]      wr_addr,
    input  logic [BYTE_W-1:0]      wr_data,
    input  logic [BYTE_W-1:0]      rd_addr,
    output logic [BYTE_W-1:0]      rd_data,
    output logic [NREG*BYTE_W-1:0] regs_o
);

    logic [BYTE_W-1:0] mem_q [NREG];

    // Register storage with address-matched write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_addr == BYTE_W'(i)) begin
                    mem_q[i] <= wr_data;
                end
            end
        end
    end

    // Read mux that returns zero for unmapped addresses.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == BYTE_W'(i)) begin
                rd_data = mem_q[i];
            end
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_o[g*BYTE_W +: BYTE_W] = mem_q[g];
    end

endmodule

// File: rtl/spi_regport.sv
// Top level of the serial register control port. It synchronises the
// host lines, runs the frame sequencer, holds the register bank and
// drives the tri-state read line.
// Assumes: sck_i holds each level for at least 4 clk cycles, and cs_n_i
// changes only while sck_i is low.
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int NREG = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ID = DEFAULT_DEV_ID
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n_i,
    input  logic                   sck_i,
    input  logic                   mosi_i,
    output logic                   miso_o,
    output logic                   miso_oe_o,
    output logic [NREG*BYTE_W-1:0] regs_o
);

    localparam int N_LINES = 3;
    localparam int L_CS    = 2;
    localparam int L_SCK   = 1;
    localparam int L_MOSI  = 0;

    logic [N_LINES-1:0] lvl, rise, fall;
    logic               cs_s;
    logic [BYTE_W-1:0]  rd_ptr, rd_data, wr_addr, wr_data;
    logic               wr_en, miso_bit, miso_oe;
    phase_t             phase;

    spi_regport_sync #(
        .WIDTH   (N_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n_i, sck_i, mosi_i}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    assign cs_s = lvl[L_CS];

    spi_regport_frame #(
        .DEV_ID (DEV_ID)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_s),
        .sck_rise   (rise[L_SCK]),
        .sck_fall   (fall[L_SCK]),
        .mosi       (lvl[L_MOSI]),
        .rd_data    (rd_data),
        .ptr_o      (rd_ptr),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .miso_bit_o (miso_bit),
        .miso_oe_o  (miso_oe),
        .phase_o    (phase)
    );

    spi_regport_regfile #(
        .NREG (NREG)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_ptr),
        .rd_data (rd_data),
        .regs_o  (regs_o)
    );

    // Output line, driven only while the read phase is shifting.
    assign miso_o    = miso_oe ? miso_bit : 1'bz;
    assign miso_oe_o = miso_oe;

endmodule

// File: rtl/spi_regport_chk.sv
// Property checker for spi_regport, attached to it by bind.
module spi_regport_chk
    import spi_regport_pkg::*;
#(
    parameter int NREG = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cs_s,
    input phase_t                 phase,
    input logic                   wr_en,
    input logic [BYTE_W-1:0]      wr_addr,
    input logic [BYTE_W-1:0]      wr_data,
    input logic [BYTE_W-1:0]      ptr,
    input logic                   miso_oe,
    input logic [NREG*BYTE_W-1:0] regs
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (regs == '0 && !miso_oe));

    p_ignore_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_IGNORE |-> !wr_en);

    p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr < BYTE_W'(NREG)) |=>
        regs[$past(wr_addr)*BYTE_W +: BYTE_W] == $past(wr_data));

    p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ptr == BYTE_W'(wr_addr + 8'd1));

    p_oe_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> phase == PH_RDATA);

    p_oe_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !miso_oe);

    p_oob_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= BYTE_W'(NREG)) |=> $stable(regs));

endmodule

bind spi_regport spi_regport_chk #(.NREG(NREG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .phase   (phase),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ptr     (rd_ptr),
    .miso_oe (miso_oe),
    .regs    (regs_o)
);

// File: tb/tb_spi_regport.sv
module tb_spi_regport;

    localparam int NREG = 8;
    localparam int HP = 8;
    localparam logic [6:0] ID = 7'b1001100;
    localparam logic [7:0] WR_HDR = {ID, 1'b0};
    localparam logic [7:0] RD_HDR = {ID, 1'b1};
    localparam logic [7:0] BAD_WR = {7'b1001101, 1'b0};
    localparam logic [7:0] BAD_RD = {7'b1001101, 1'b1};

    // {pointer, data} pairs applied by the vector loop
    localparam logic [15:0] VEC [8] = '{
        16'h005A, 16'h01A5, 16'h02FF, 16'h0301,
        16'h0480, 16'h053C, 16'h06C3, 16'h077E
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso, miso_oe;
    logic [NREG*8-1:0] regs;
    logic [NREG*8-1:0] snap;
    logic [7:0] rb;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    spi_regport #(.NREG(NREG)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_i    (cs_n),
        .sck_i     (sck),
        .mosi_i    (mosi),
        .miso_o    (miso),
        .miso_oe_o (miso_oe),
        .regs_o    (regs)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic frame_open();
        cs_n = 1'b0;
        wait_clk(HP);
    endtask

    task automatic frame_close();
        wait_clk(HP);
        cs_n = 1'b1;
        wait_clk(4 * HP);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = b[i];
            wait_clk(HP);
            sck = 1'b1;
            wait_clk(HP);
            sck = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic read_byte(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wait_clk(HP);
            b[i] = miso;
            sck = 1'b1;
            wait_clk(HP);
            sck = 1'b0;
        end
    endtask

    function automatic logic [7:0] reg_at(input int k);
        return regs[k*8 +: 8];
    endfunction

    task automatic set_ptr(input logic [7:0] p);
        frame_open();
        send_byte(WR_HDR);
        send_byte(p);
        frame_close();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_clk(4);
        // R1: reset state
        check("R1 regs after reset", 64'(regs), 64'h0);
        check("R1 oe after reset", 64'(miso_oe), 64'h0);
        rst_n = 1'b1;
        wait_clk(4);
        check("R7 oe idle", 64'(miso_oe), 64'h0);

        // R2 R4 R6: vector loop of single writes and read-back
        foreach (VEC[v]) begin
            frame_open();
            send_byte(WR_HDR);
            send_byte(VEC[v][15:8]);
            send_byte(VEC[v][7:0]);
            check("R4 single write", 64'(reg_at(int'(VEC[v][15:8]))), 64'(VEC[v][7:0]));
            frame_close();
            set_ptr(VEC[v][15:8]);
            frame_open();
            send_byte(RD_HDR);
            check("R7 oe low in address byte", 64'(miso_oe), 64'h0);
            read_byte(rb);
            check("R6 read back", 64'(rb), 64'(VEC[v][7:0]));
            check("R7 oe high in read data", 64'(miso_oe), 64'h1);
            frame_close();
            check("R7 oe low after frame", 64'(miso_oe), 64'h0);
        end

        // R3: wrong identifier write changes nothing
        snap = regs;
        frame_open();
        send_byte(BAD_WR);
        send_byte(8'h00);
        send_byte(8'hEE);
        frame_close();
        check("R3 bad id write ignored", 64'(regs), 64'(snap));

        // R3: wrong identifier read never enables output
        frame_open();
        send_byte(BAD_RD);
        read_byte(rb);
        check("R3 bad id read oe", 64'(miso_oe), 64'h0);
        frame_close();

        // R5: burst write fills consecutive registers
        frame_open();
        send_byte(WR_HDR);
        send_byte(8'h02);
        send_byte(8'h11);
        send_byte(8'h22);
        send_byte(8'h33);
        frame_close();
        check("R5 burst reg2", 64'(reg_at(2)), 64'h11);
        check("R5 burst reg3", 64'(reg_at(3)), 64'h22);
        check("R5 burst reg4", 64'(reg_at(4)), 64'h33);

        // R6 R10: burst read from pointer left by a previous frame
        set_ptr(8'h02);
        frame_open();
        send_byte(RD_HDR);
        read_byte(rb);
        check("R10 read at retained ptr", 64'(rb), 64'h11);
        read_byte(rb);
        check("R6 burst read 2nd", 64'(rb), 64'h22);
        read_byte(rb);
        check("R6 burst read 3rd", 64'(rb), 64'h33);
        frame_close();

        // R8: partial data byte writes nothing
        snap = regs;
        frame_open();
        send_byte(WR_HDR);
        send_byte(8'h05);
        send_bits(8'h00, 5);
        frame_close();
        check("R8 partial data discarded", 64'(regs), 64'(snap));

        // R8: partial pointer byte leaves pointer as set before
        set_ptr(8'h01);
        frame_open();
        send_byte(WR_HDR);
        send_bits(8'h06, 3);
        frame_close();
        frame_open();
        send_byte(RD_HDR);
        read_byte(rb);
        check("R8 pointer kept after partial", 64'(rb), 64'h00A5);
        frame_close();

        // R9: out-of-range write dropped, read returns zero
        snap = regs;
        frame_open();
        send_byte(WR_HDR);
        send_byte(8'h09);
        send_byte(8'hAA);
        frame_close();
        check("R9 oob write dropped", 64'(regs), 64'(snap));
        set_ptr(8'd200);
        frame_open();
        send_byte(RD_HDR);
        read_byte(rb);
        check("R9 oob read zero", 64'(rb), 64'h00);
        frame_close();

        // R5 R9: burst past the last register does not wrap into reg0
        frame_open();
        send_byte(WR_HDR);
        send_byte(8'h07);
        send_byte(8'h77);
        send_byte(8'h88);
        frame_close();
        check("R5 last reg written", 64'(reg_at(7)), 64'h77);
        check("R9 reg0 untouched past end", 64'(reg_at(0)), 64'h5A);

        // R1: reset clears the bank again
        rst_n = 1'b0;
        wait_clk(2);
        rst_n = 1'b1;
        wait_clk(1);
        check("R1 regs cleared by reset", 64'(regs), 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule